// File: doc/BRIEF.md
# Shared-Clock Two-Port RAM with Write-Clash Resolution

This block is a synchronous memory with two ports, A and B, that both run on one clock. Each port can read or write any word on every rising edge, and its read data comes out of a register one cycle later. The storage is a plain register array with no reset, so a user writes a word before reading it.

When both ports write the same word on the same edge, that is a write clash. A build-time policy decides which word is stored: port A's data, port B's data, or a fixed poison word that marks the location as damaged. A clash also raises a sticky interrupt and records the clashing address. A two-state controller holds both. FL_IDLE moves to FL_HELD on a clash (transition CATCH). FL_HELD returns to FL_IDLE on the clear input (transition RELEASE).

Each port has its own build-time mode for a read on the address it is writing. In old-word mode the port returns the previous contents. In new-word mode it returns the word that is actually stored. In hold mode its output stays unchanged. When a port reads an address that the other port is writing, it gets the old contents.

Top module: `dpram_collide`

## Requirements
- R1: When a port does not write, its `*_rdata` shows the word stored at its address one rising edge after the address is applied.
- R2: When both ports write different addresses on the same edge, both words are stored.
- R3: When one port writes an address and the other port reads that same address on the same edge, the reading port returns the word held before that edge.
- R4: A clash exists only when `a_we` and `b_we` are both 1 and `a_addr` equals `b_addr` at a rising edge. A clash without `irq_clr` makes `irq` 1 after that edge, and `irq` never rises without a clash.
- R5: With `POLICY` = POL_A_WINS (encoding 0), a clash stores `a_wdata`.
- R6: With `POLICY` = POL_B_WINS (encoding 1), a clash stores `b_wdata`.
- R7: With `POLICY` = POL_POISON (encoding 2), a clash stores the `POISON` parameter word (default 16'hDEAD).
- R8: In mode RD_OLD (encoding 0), a writing port's `*_rdata` shows the word held at its address before the write.
- R9: In mode RD_NEW (encoding 1), a writing port's `*_rdata` shows the word stored at its address by that edge. After a clash this is the word chosen by the policy.
- R10: In mode RD_HOLD (encoding 2), a writing port's `*_rdata` keeps its previous value.
- R11: `irq` stays 1 until an edge with `irq_clr` = 1 and is 0 after that edge. `irq_clr` takes priority over a clash on the same edge.
- R12: `irq_addr` takes the address of the clash that sets `irq`. Later clashes do not change it while `irq` stays 1.
- R13: While `rst_n` is 0, `a_rdata`, `b_rdata`, `irq` and `irq_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_clr | input | 1 | Synchronous clear of the clash interrupt |
| a_we | input | 1 | Port A write enable |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered read data |
| b_we | input | 1 | Port B write enable |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered read data |
| irq | output | 1 | Sticky write-clash interrupt |
| irq_addr | output | AW | Address of the clash that set the interrupt |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it: read data for both ports, the interrupt, and the captured clash address. The bench changes inputs on the falling edge. At that moment the driver queues the values its reference model predicts. The monitor pops that entry and compares it 1 ns after the next rising edge, so each comparison sees the edge that consumed those inputs and no other. Three instances with different policy and mode settings receive the same traffic, which covers every policy and every read mode on each port.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        POL_A_WINS = 2'd0,
        POL_B_WINS = 2'd1,
        POL_POISON = 2'd2
    } policy_e;

    typedef enum logic [1:0] {
        RD_OLD  = 2'd0,
        RD_NEW  = 2'd1,
        RD_HOLD = 2'd2
    } rd_mode_e;

    typedef enum logic {
        FL_IDLE = 1'b0,
        FL_HELD = 1'b1
    } flag_state_e;

endpackage

// File: rtl/dpram_clash_det.sv
module dpram_clash_det #(
    parameter int AW = 6
) (
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    output logic          clash
);
    // Same-word write from both ports on this edge
    always_comb clash = a_we && b_we && (a_addr == b_addr);
endmodule

// File: rtl/dpram_store.sv
module dpram_store
    import dpram_pkg::*;
#(
    parameter int          AW     = 6,
    parameter int          DW     = 16,
    parameter policy_e     POLICY = POL_A_WINS,
    parameter logic [DW-1:0] POISON = 16'hDEAD
) (
    input  logic          clk,
    input  logic          clash,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] a_old,
    output logic [DW-1:0] b_old,
    output logic [DW-1:0] a_new,
    output logic [DW-1:0] b_new
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          a_go;
    logic          b_go;
    logic [DW-1:0] a_word;

    // Resolve a clash into at most one write per word
    generate
        if (POLICY == POL_B_WINS) begin : g_bwin
            always_comb begin
                a_go   = a_we && !clash;
                b_go   = b_we;
                a_word = a_wdata;
            end
        end else if (POLICY == POL_POISON) begin : g_poison
            always_comb begin
                a_go   = a_we;
                b_go   = b_we && !clash;
                a_word = clash ? POISON : a_wdata;
            end
        end else begin : g_awin
            always_comb begin
                a_go   = a_we;
                b_go   = b_we && !clash;
                a_word = a_wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (a_go) mem[a_addr] <= a_word;
        if (b_go) mem[b_addr] <= b_wdata;
    end

    always_comb begin
        a_old = mem[a_addr];
        b_old = mem[b_addr];
        if (a_go)                        a_new = a_word;
        else if (b_go && b_addr == a_addr) a_new = b_wdata;
        else                             a_new = a_old;
        if (b_go)                        b_new = b_wdata;
        else if (a_go && a_addr == b_addr) b_new = a_word;
        else                             b_new = b_old;
    end
endmodule

// File: rtl/dpram_rd_port.sv
module dpram_rd_port
    import dpram_pkg::*;
#(
    parameter int       DW   = 16,
    parameter rd_mode_e MODE = RD_OLD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] new_word,
    output logic [DW-1:0] rdata
);
    generate
        if (MODE == RD_NEW) begin : g_new
            always_ff @(posedge clk) begin
                if (!rst_n)  rdata <= '0;
                else if (we) rdata <= new_word;
                else         rdata <= old_word;
            end
        end else if (MODE == RD_HOLD) begin : g_hold
            always_ff @(posedge clk) begin
                if (!rst_n)   rdata <= '0;
                else if (!we) rdata <= old_word;
            end
        end else begin : g_old
            always_ff @(posedge clk) begin
                if (!rst_n) rdata <= '0;
                else        rdata <= old_word;
            end
        end
    endgenerate
endmodule

// File: rtl/dpram_flag_fsm.sv
module dpram_flag_fsm
    import dpram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clash,
    input  logic          clr,
    input  logic [AW-1:0] clash_addr,
    output logic          irq,
    output logic [AW-1:0] irq_addr
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_IDLE: if (clash && !clr) state_d = FL_HELD;   // CATCH
            FL_HELD: if (clr)           state_d = FL_IDLE;   // RELEASE
            default: state_d = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_addr <= '0;
        else if (state_q == FL_IDLE && state_d == FL_HELD)
            irq_addr <= clash_addr;
    end

    always_comb irq = (state_q == FL_HELD);
endmodule

// File: rtl/dpram_collide.sv
module dpram_collide
    import dpram_pkg::*;
#(
    parameter int            AW     = 6,
    parameter int            DW     = 16,
    parameter policy_e       POLICY = POL_A_WINS,
    parameter rd_mode_e      MODE_A = RD_OLD,
    parameter rd_mode_e      MODE_B = RD_NEW,
    parameter logic [DW-1:0] POISON = 16'hDEAD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_clr,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          irq,
    output logic [AW-1:0] irq_addr
);
    logic          clash;
    logic [DW-1:0] a_old, b_old, a_new, b_new;

    dpram_clash_det #(.AW(AW)) u_det (
        .a_we(a_we), .a_addr(a_addr), .b_we(b_we), .b_addr(b_addr), .clash(clash)
    );

    dpram_store #(.AW(AW), .DW(DW), .POLICY(POLICY), .POISON(POISON)) u_store (
        .clk(clk), .clash(clash),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
        .a_old(a_old), .b_old(b_old), .a_new(a_new), .b_new(b_new)
    );

    dpram_rd_port #(.DW(DW), .MODE(MODE_A)) u_rd_a (
        .clk(clk), .rst_n(rst_n), .we(a_we),
        .old_word(a_old), .new_word(a_new), .rdata(a_rdata)
    );

    dpram_rd_port #(.DW(DW), .MODE(MODE_B)) u_rd_b (
        .clk(clk), .rst_n(rst_n), .we(b_we),
        .old_word(b_old), .new_word(b_new), .rdata(b_rdata)
    );

    dpram_flag_fsm #(.AW(AW)) u_flag (
        .clk(clk), .rst_n(rst_n), .clash(clash), .clr(irq_clr),
        .clash_addr(a_addr), .irq(irq), .irq_addr(irq_addr)
    );
endmodule

// File: rtl/dpram_collide_chk.sv
module dpram_collide_chk
    import dpram_pkg::*;
#(
    parameter int       AW     = 6,
    parameter int       DW     = 16,
    parameter rd_mode_e MODE_A = RD_OLD,
    parameter rd_mode_e MODE_B = RD_NEW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq_clr,
    input logic          a_we,
    input logic [AW-1:0] a_addr,
    input logic [DW-1:0] a_rdata,
    input logic          b_we,
    input logic [AW-1:0] b_addr,
    input logic [DW-1:0] b_rdata,
    input logic          irq,
    input logic [AW-1:0] irq_addr
);
    logic same_w;
    always_comb same_w = a_we && b_we && (a_addr == b_addr);

    AST_CLASH_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (same_w && !irq_clr) |=> irq); // R4
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !same_w) |=> !irq); // R4
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R11
    AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clr |=> !irq); // R11
    AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> $stable(irq_addr)); // R12
    AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && same_w && !irq_clr) |=> (irq_addr == $past(a_addr))); // R12
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE_A == RD_HOLD && a_we) |=> $stable(a_rdata)); // R10
    AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE_B == RD_HOLD && b_we) |=> $stable(b_rdata)); // R10
endmodule

bind dpram_collide dpram_collide_chk #(
    .AW(AW), .DW(DW), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr),
    .a_we(a_we), .a_addr(a_addr), .a_rdata(a_rdata),
    .b_we(b_we), .b_addr(b_addr), .b_rdata(b_rdata),
    .irq(irq), .irq_addr(irq_addr)
);

// File: tb/test_dpram_collide.sv
`timescale 1ns/1ps
module test_dpram_collide;
    import dpram_pkg::*;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] POISON = 16'hDEAD;
    localparam policy_e  POL [3] = '{POL_A_WINS, POL_POISON, POL_B_WINS};
    localparam rd_mode_e MA  [3] = '{RD_OLD, RD_HOLD, RD_NEW};
    localparam rd_mode_e MB  [3] = '{RD_NEW, RD_OLD, RD_HOLD};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_clr = 1'b0;
    logic a_we = 1'b0, b_we = 1'b0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] ra [3];
    logic [DW-1:0] rb [3];
    logic irq_v [3];
    logic [AW-1:0] ia_v [3];

    always #4 clk = ~clk;

    dpram_collide #(.AW(AW), .DW(DW), .POLICY(POL_A_WINS), .MODE_A(RD_OLD),
                    .MODE_B(RD_NEW), .POISON(POISON)) i_dpram_collide (
        .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(ra[0]),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rb[0]),
        .irq(irq_v[0]), .irq_addr(ia_v[0]));
    dpram_collide #(.AW(AW), .DW(DW), .POLICY(POL_POISON), .MODE_A(RD_HOLD),
                    .MODE_B(RD_OLD), .POISON(POISON)) i_dpram_poison (
        .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(ra[1]),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rb[1]),
        .irq(irq_v[1]), .irq_addr(ia_v[1]));
    dpram_collide #(.AW(AW), .DW(DW), .POLICY(POL_B_WINS), .MODE_A(RD_NEW),
                    .MODE_B(RD_HOLD), .POISON(POISON)) i_dpram_bwins (
        .clk(clk), .rst_n(rst_n), .irq_clr(irq_clr),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(ra[2]),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(rb[2]),
        .irq(irq_v[2]), .irq_addr(ia_v[2]));

    typedef struct {
        bit            chk;
        logic [DW-1:0] ea [3];
        logic [DW-1:0] eb [3];
        logic          eirq;
        logic [AW-1:0] eia;
    } exp_t;

    exp_t q [$];
    int checks = 0;
    int errors = 0;
    logic [DW-1:0] mdl [3][DEPTH];
    logic [DW-1:0] pa [3];
    logic [DW-1:0] pb [3];
    logic          m_irq = 1'b0;
    logic [AW-1:0] m_ia = '0;

    task automatic check(input bit ok, input string what, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", what, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle at the falling edge and queue the predicted result
    task automatic cyc(input logic awe, input logic [AW-1:0] aa, input logic [DW-1:0] ad,
                       input logic bwe, input logic [AW-1:0] ba, input logic [DW-1:0] bd,
                       input logic clr, input bit chk);
        exp_t e;
        logic coll;
        @(negedge clk);
        a_we = awe; a_addr = aa; a_wdata = ad;
        b_we = bwe; b_addr = ba; b_wdata = bd; irq_clr = clr;
        coll = awe && bwe && (aa == ba);
        e.chk = chk;
        for (int k = 0; k < 3; k++) begin
            logic [DW-1:0] oa, ob;
            oa = mdl[k][aa];
            ob = mdl[k][ba];
            if (coll) begin
                if (POL[k] == POL_A_WINS)      mdl[k][aa] = ad;  // R5
                else if (POL[k] == POL_B_WINS) mdl[k][aa] = bd;  // R6
                else                           mdl[k][aa] = POISON; // R7
            end else begin
                if (awe) mdl[k][aa] = ad;  // R2
                if (bwe) mdl[k][ba] = bd;
            end
            // R1 R3 R8 R9 R10
            if (!awe || MA[k] == RD_OLD) pa[k] = oa;
            else if (MA[k] == RD_NEW)    pa[k] = mdl[k][aa];
            if (!bwe || MB[k] == RD_OLD) pb[k] = ob;
            else if (MB[k] == RD_NEW)    pb[k] = mdl[k][ba];
            e.ea[k] = pa[k];
            e.eb[k] = pb[k];
        end
        // R11 R12: clear first, capture only from idle
        if (clr) m_irq = 1'b0;
        else if (coll && !m_irq) begin m_irq = 1'b1; m_ia = aa; end
        e.eirq = m_irq;
        e.eia  = m_ia;
        q.push_back(e);
    endtask

    // Monitor: compare 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.chk) begin
                    for (int k = 0; k < 3; k++) begin
                        check(ra[k] === e.ea[k], $sformatf("R1 R8 R9 R10 inst%0d a_rdata", k), ra[k], e.ea[k]);
                        check(rb[k] === e.eb[k], $sformatf("R3 R5 R6 R7 inst%0d b_rdata", k), rb[k], e.eb[k]);
                        check(irq_v[k] === e.eirq, $sformatf("R4 R11 inst%0d irq", k),
                              DW'(irq_v[k]), DW'(e.eirq));
                        check(ia_v[k] === e.eia, $sformatf("R12 inst%0d irq_addr", k),
                              DW'(ia_v[k]), DW'(e.eia));
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            pa[k] = '0; pb[k] = '0;
            for (int i = 0; i < DEPTH; i++) mdl[k][i] = '0;
        end
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < 3; k++) begin   // R13
            check(ra[k] === '0, "R13 reset a_rdata", ra[k], '0);
            check(rb[k] === '0, "R13 reset b_rdata", rb[k], '0);
            check(irq_v[k] === 1'b0, "R13 reset irq", DW'(irq_v[k]), '0);
            check(ia_v[k] === '0, "R13 reset irq_addr", DW'(ia_v[k]), '0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Fill every word; first outputs of old-word ports are unknown, so unchecked
        for (int i = 0; i < DEPTH / 2; i++)
            cyc(1'b1, AW'(i), DW'(16'h1000 + i), 1'b1, AW'(i + DEPTH / 2), DW'(16'h2000 + i), 1'b0, 1'b0);
        cyc(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, 1'b0);

        // R1: plain reads
        cyc(1'b0, 6'd3, '0, 1'b0, 6'd40, '0, 1'b0, 1'b1);
        // R2: both write different words, then read them back
        cyc(1'b1, 6'd5, 16'hAAAA, 1'b1, 6'd6, 16'hBBBB, 1'b0, 1'b1);
        cyc(1'b0, 6'd6, '0, 1'b0, 6'd5, '0, 1'b0, 1'b1);
        // R3: A writes 7 while B reads 7
        cyc(1'b1, 6'd7, 16'h7777, 1'b0, 6'd7, '0, 1'b0, 1'b1);
        cyc(1'b0, 6'd7, '0, 1'b0, 6'd7, '0, 1'b0, 1'b1);
        // R4 R5 R6 R7 R12: clash at 9, read back the resolved word
        cyc(1'b1, 6'd9, 16'h1111, 1'b1, 6'd9, 16'h2222, 1'b0, 1'b1);
        cyc(1'b0, 6'd9, '0, 1'b0, 6'd9, '0, 1'b0, 1'b1);
        // R12: second clash elsewhere leaves the captured address
        cyc(1'b1, 6'd12, 16'h3333, 1'b1, 6'd12, 16'h4444, 1'b0, 1'b1);
        // R11: clear, and clear wins over a same-cycle clash
        cyc(1'b0, 6'd0, '0, 1'b0, 6'd1, '0, 1'b1, 1'b1);
        cyc(1'b1, 6'd14, 16'h5555, 1'b1, 6'd14, 16'h6666, 1'b1, 1'b1);
        cyc(1'b1, 6'd15, 16'h5151, 1'b1, 6'd15, 16'h6161, 1'b0, 1'b1);
        // R8 R9 R10: writes with no clash on both ports
        cyc(1'b1, 6'd20, 16'hC0DE, 1'b1, 6'd21, 16'hF00D, 1'b0, 1'b1);
        cyc(1'b0, 6'd20, '0, 1'b0, 6'd21, '0, 1'b1, 1'b1);

        // Random traffic with frequent forced address conflicts
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] aa, ba;
            aa = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, DEPTH - 1)) : AW'($urandom_range(0, 3));
            ba = ($urandom_range(0, 2) == 0) ? aa : AW'($urandom_range(0, 3));
            cyc(1'($urandom_range(0, 1)), aa, DW'($urandom),
                1'($urandom_range(0, 1)), ba, DW'($urandom),
                1'($urandom_range(0, 19) == 0), 1'b1);
        end

        @(negedge clk);
        a_we = 1'b0; b_we = 1'b0; irq_clr = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule